// File: doc/BRIEF.md
# Wake-Gated APB Register Completer

This block is an APB completer that holds a small bank of word registers. Reads and writes arrive over the standard two-phase APB handshake. In the default mode the completer does not finish a transfer until the requester's wakeup line has been seen high during that transfer. This lets a clock controller upstream bring the clock back before any transfer is allowed to finish. A parameter selects a simpler mode in which completion follows a fixed number of wait states and the wakeup line is ignored.

Alongside each write, the completer stores two tags that the requester sends: a request tag and a write tag. It returns them later on the response sideband outputs. The read tag output carries the stored write tag of the register being read, and only during a read completion. The completion tag output carries the low bits of the register's request tag during any completion that hits a mapped register. Outside those windows both tag outputs are held at zero.

Addresses are byte addresses. An access whose word index lies beyond the register bank completes with an error and changes nothing. The completion tag must be no wider than 16 bits, and the read tag no wider than half the data width.

Top module: `apb_wake_regs`

## Requirements
- R1: After synchronous reset every register word and both of its stored tags are zero. While no transfer is in progress, bus_ready, bus_rdata, bus_err, rd_tag_out and done_tag_out are all zero.
- R2: The word index is bus_addr[ADDR_W-1:log2(DATA_W/8)], and the lower address bits are ignored. A write whose index is below NUM_REGS stores bus_wdata, req_tag and wr_tag into that register in its completion cycle. A later read completion of that register presents the stored word on bus_rdata.
- R3: With WAKE_GATE=1, bus_ready stays low in every access cycle until wake_req has been high in some cycle of the current transfer, counting from setup (bus_sel high). When wake_req was high in setup, bus_ready rises in the first access cycle. Otherwise it rises in the first access cycle in which wake_req is high. A wake_req pulse while bus_sel is low does not count.
- R4: The record that wake_req was seen is cleared at completion, so each new transfer must see wake_req again.
- R5: During a read completion of a mapped register, rd_tag_out equals the wr_tag stored by that register's most recent write. When RD_USER_W is the larger width it is zero-extended; otherwise it is truncated to the low bits. At all other times rd_tag_out is zero, including write completions.
- R6: During any completion of a mapped register, done_tag_out equals the low DONE_USER_W bits of the request tag the register holds once the access is done. For a write this is the incoming req_tag. At all other times done_tag_out is zero, error completions included.
- R7: An access whose index is NUM_REGS or more completes with bus_err high, with bus_rdata, rd_tag_out and done_tag_out zero, and leaves every register unchanged. bus_err is low in all other cycles.
- R8: With WAKE_GATE=0, bus_ready rises in the access cycle that follows exactly FIXED_WAITS access cycles with bus_ready low, whatever wake_req does.
- R9: bus_ready is high only while bus_sel and bus_enable are both high. bus_rdata is nonzero only during a read completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Completer select |
| bus_enable | input | 1 | Access-phase marker |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| req_tag | input | REQ_USER_W | Request sideband tag, stable from setup to completion |
| wr_tag | input | WR_USER_W | Write-data sideband tag, stable from setup to completion |
| wake_req | input | 1 | Requester wakeup indication, registered at its source |
| bus_rdata | output | DATA_W | Read data, valid at read completion |
| bus_ready | output | 1 | Transfer completes in this access cycle |
| bus_err | output | 1 | Error response for an unmapped index |
| rd_tag_out | output | RD_USER_W | Read-response sideband tag |
| done_tag_out | output | DONE_USER_W | Completion sideband tag |

## Verification
The stall behaviour is tried with wake_req placed in several positions: high from setup, rising in the first access cycle, and rising several cycles later. The number of stall cycles measured for each position separates a completer that counts setup from one that does not, and separates both from one that ignores the wakeup line. A transfer without wake in setup, placed right after a transfer that ended with wake high, shows whether the seen-wake record is cleared. An idle-time wake pulse shows whether wake is counted outside a transfer. Reads are made at aliased and offset addresses and at unmapped indices, which exposes index decoding that wraps or uses the byte bits. A second instance in fixed-wait mode, run with wake held low, shows that the wait count alone sets completion.

// File: rtl/apb_wake_pkg.sv
package apb_wake_pkg;

    // Kind of response presented in the current cycle
    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_WR_OK = 2'd1,
        RSP_RD_OK = 2'd2,
        RSP_ERR   = 2'd3
    } rsp_kind_e;

    localparam int DONE_USER_MAX_W = 16;

    // Number of byte-offset bits below the word index
    function automatic int offset_bits(input int data_w);
        return $clog2(data_w / 8);
    endfunction

    function automatic rsp_kind_e classify(input logic done, input logic wr, input logic hit);
        if (!done)
            return RSP_NONE;
        if (!hit)
            return RSP_ERR;
        return wr ? RSP_WR_OK : RSP_RD_OK;
    endfunction

endpackage

// File: rtl/apb_wake_ready.sv
module apb_wake_ready #(
    parameter bit WAKE_GATE   = 1'b1,
    parameter int FIXED_WAITS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic enable,
    input  logic wake,
    output logic ready
);

    generate
        if (WAKE_GATE) begin : g_wake
            logic woken_q;

            always_ff @(posedge clk) begin
                if (rst)
                    woken_q <= 1'b0;
                else if (!sel || ready)
                    woken_q <= 1'b0;
                else if (wake)
                    woken_q <= 1'b1;
            end

            assign ready = sel & enable & (woken_q | wake);
        end else begin : g_fixed
            localparam int CW = (FIXED_WAITS > 0) ? $clog2(FIXED_WAITS + 1) : 1;
            logic [CW-1:0] wait_q;
            logic          unused_wake;

            assign unused_wake = wake;

            always_ff @(posedge clk) begin
                if (rst)
                    wait_q <= '0;
                else if (!sel || ready)
                    wait_q <= '0;
                else if (enable)
                    wait_q <= wait_q + 1'b1;
            end

            assign ready = sel & enable & (wait_q == CW'(FIXED_WAITS));
        end
    endgenerate

endmodule

// File: rtl/apb_wake_regfile.sv
module apb_wake_regfile #(
    parameter int DATA_W     = 32,
    parameter int NUM_REGS   = 8,
    parameter int IDX_W      = 4,
    parameter int REQ_USER_W = 8,
    parameter int WR_USER_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [REQ_USER_W-1:0] atag,
    input  logic [WR_USER_W-1:0]  wtag,
    output logic [DATA_W-1:0]     rd_data,
    output logic [REQ_USER_W-1:0] rd_atag,
    output logic [WR_USER_W-1:0]  rd_wtag
);

    typedef struct packed {
        logic [DATA_W-1:0]     data;
        logic [REQ_USER_W-1:0] atag;
        logic [WR_USER_W-1:0]  wtag;
    } slot_t;

    slot_t slot_q [NUM_REGS];
    slot_t rd_slot;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q[g] <= '0;
                else if (we && idx == IDX_W'(g))
                    slot_q[g] <= '{data: wdata, atag: atag, wtag: wtag};
            end
        end
    endgenerate

    always_comb begin
        rd_slot = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i))
                rd_slot = slot_q[i];
        end
    end

    assign rd_data = rd_slot.data;
    assign rd_atag = rd_slot.atag;
    assign rd_wtag = rd_slot.wtag;

endmodule

// File: rtl/apb_wake_resp.sv
module apb_wake_resp
    import apb_wake_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int REQ_USER_W  = 8,
    parameter int WR_USER_W   = 8,
    parameter int RD_USER_W   = 8,
    parameter int DONE_USER_W = 4
) (
    input  rsp_kind_e              kind,
    input  logic [DATA_W-1:0]      st_data,
    input  logic [REQ_USER_W-1:0]  st_atag,
    input  logic [WR_USER_W-1:0]   st_wtag,
    input  logic [REQ_USER_W-1:0]  in_atag,
    output logic [DATA_W-1:0]      rdata,
    output logic [RD_USER_W-1:0]   rd_tag,
    output logic [DONE_USER_W-1:0] done_tag,
    output logic                   err
);

    logic [RD_USER_W-1:0]   wtag_fit;
    logic [DONE_USER_W-1:0] st_atag_fit;
    logic [DONE_USER_W-1:0] in_atag_fit;
    logic                   unused_hi;

    assign unused_hi = ^{st_wtag, st_atag, in_atag};

    generate
        if (RD_USER_W <= WR_USER_W) begin : g_rd_cut
            assign wtag_fit = st_wtag[RD_USER_W-1:0];
        end else begin : g_rd_ext
            assign wtag_fit = {{(RD_USER_W - WR_USER_W){1'b0}}, st_wtag};
        end

        if (DONE_USER_W <= REQ_USER_W) begin : g_dn_cut
            assign st_atag_fit = st_atag[DONE_USER_W-1:0];
            assign in_atag_fit = in_atag[DONE_USER_W-1:0];
        end else begin : g_dn_ext
            assign st_atag_fit = {{(DONE_USER_W - REQ_USER_W){1'b0}}, st_atag};
            assign in_atag_fit = {{(DONE_USER_W - REQ_USER_W){1'b0}}, in_atag};
        end
    endgenerate

    always_comb begin
        rdata    = '0;
        rd_tag   = '0;
        done_tag = '0;
        err      = 1'b0;
        case (kind)
            RSP_RD_OK: begin
                rdata    = st_data;
                rd_tag   = wtag_fit;
                done_tag = st_atag_fit;
            end
            RSP_WR_OK: done_tag = in_atag_fit;
            RSP_ERR:   err      = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/apb_wake_regs.sv
module apb_wake_regs
    import apb_wake_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 6,
    parameter int NUM_REGS    = 8,
    parameter int REQ_USER_W  = 8,
    parameter int WR_USER_W   = 8,
    parameter int RD_USER_W   = 8,
    parameter int DONE_USER_W = 4,
    parameter bit WAKE_GATE   = 1'b1,
    parameter int FIXED_WAITS = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_sel,
    input  logic                   bus_enable,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic [REQ_USER_W-1:0]  req_tag,
    input  logic [WR_USER_W-1:0]   wr_tag,
    input  logic                   wake_req,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_ready,
    output logic                   bus_err,
    output logic [RD_USER_W-1:0]   rd_tag_out,
    output logic [DONE_USER_W-1:0] done_tag_out
);

    localparam int OFS_W = offset_bits(DATA_W);
    localparam int IDX_W = ADDR_W - OFS_W;

    logic [IDX_W-1:0]      idx;
    logic                  hit;
    logic                  unused_ofs;
    rsp_kind_e             kind;
    logic [DATA_W-1:0]     st_data;
    logic [REQ_USER_W-1:0] st_atag;
    logic [WR_USER_W-1:0]  st_wtag;

    assign idx        = bus_addr[ADDR_W-1:OFS_W];
    assign unused_ofs = ^bus_addr[OFS_W-1:0];
    assign hit        = (int'(idx) < NUM_REGS);
    assign kind       = classify(bus_ready, bus_write, hit);

    apb_wake_ready #(
        .WAKE_GATE  (WAKE_GATE),
        .FIXED_WAITS(FIXED_WAITS)
    ) u_ready (
        .clk   (clk),
        .rst   (rst),
        .sel   (bus_sel),
        .enable(bus_enable),
        .wake  (wake_req),
        .ready (bus_ready)
    );

    apb_wake_regfile #(
        .DATA_W    (DATA_W),
        .NUM_REGS  (NUM_REGS),
        .IDX_W     (IDX_W),
        .REQ_USER_W(REQ_USER_W),
        .WR_USER_W (WR_USER_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (kind == RSP_WR_OK),
        .idx    (idx),
        .wdata  (bus_wdata),
        .atag   (req_tag),
        .wtag   (wr_tag),
        .rd_data(st_data),
        .rd_atag(st_atag),
        .rd_wtag(st_wtag)
    );

    apb_wake_resp #(
        .DATA_W     (DATA_W),
        .REQ_USER_W (REQ_USER_W),
        .WR_USER_W  (WR_USER_W),
        .RD_USER_W  (RD_USER_W),
        .DONE_USER_W(DONE_USER_W)
    ) u_resp (
        .kind    (kind),
        .st_data (st_data),
        .st_atag (st_atag),
        .st_wtag (st_wtag),
        .in_atag (req_tag),
        .rdata   (bus_rdata),
        .rd_tag  (rd_tag_out),
        .done_tag(done_tag_out),
        .err     (bus_err)
    );

endmodule

// File: rtl/apb_wake_regs_chk.sv
module apb_wake_regs_chk #(
    parameter bit WAKE_GATE   = 1'b1,
    parameter int FIXED_WAITS = 2,
    parameter int RD_USER_W   = 8,
    parameter int DONE_USER_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sel,
    input logic                   enable,
    input logic                   write,
    input logic                   wake,
    input logic                   ready,
    input logic                   err,
    input logic [RD_USER_W-1:0]   rd_tag,
    input logic [DONE_USER_W-1:0] done_tag
);

    logic        seen_q;
    logic [31:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || !sel || ready)
            seen_q <= 1'b0;
        else if (wake)
            seen_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !sel || ready)
            acc_q <= '0;
        else if (enable && acc_q != 32'hFFFF_FFFF)
            acc_q <= acc_q + 32'd1;
    end

    // R3
    ready_needs_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (WAKE_GATE && ready) |-> (wake || seen_q));

    // R8
    fixed_wait_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!WAKE_GATE && ready) |-> (acc_q == 32'(FIXED_WAITS)));

    // R9
    ready_in_access_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (sel && enable));

    // R5
    rd_tag_window_chk: assert property (@(posedge clk) disable iff (rst)
        !(ready && !write) |-> (rd_tag == '0));

    // R6
    done_tag_window_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (done_tag == '0));

    // R7
    err_at_completion_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ready);

endmodule

bind apb_wake_regs apb_wake_regs_chk #(
    .WAKE_GATE  (WAKE_GATE),
    .FIXED_WAITS(FIXED_WAITS),
    .RD_USER_W  (RD_USER_W),
    .DONE_USER_W(DONE_USER_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel     (bus_sel),
    .enable  (bus_enable),
    .write   (bus_write),
    .wake    (wake_req),
    .ready   (bus_ready),
    .err     (bus_err),
    .rd_tag  (rd_tag_out),
    .done_tag(done_tag_out)
);

// File: tb/sim_apb_wake_regs.sv
module sim_apb_wake_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, en = 1'b0, wr = 1'b0, wake = 1'b0, tgt = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  au = '0, wu = '0;

    logic [31:0] rdata0, rdata1;
    logic        ready0, ready1, err0, err1;
    logic [7:0]  rdu0, rdu1;
    logic [3:0]  du0, du1;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    apb_wake_regs u0 (
        .clk(clk), .rst(rst), .bus_sel(sel & ~tgt), .bus_enable(en), .bus_write(wr),
        .bus_addr(addr), .bus_wdata(wdata), .req_tag(au), .wr_tag(wu), .wake_req(wake),
        .bus_rdata(rdata0), .bus_ready(ready0), .bus_err(err0),
        .rd_tag_out(rdu0), .done_tag_out(du0)
    );

    apb_wake_regs #(.WAKE_GATE(1'b0), .FIXED_WAITS(2)) u1 (
        .clk(clk), .rst(rst), .bus_sel(sel & tgt), .bus_enable(en), .bus_write(wr),
        .bus_addr(addr), .bus_wdata(wdata), .req_tag(au), .wr_tag(wu), .wake_req(wake),
        .bus_rdata(rdata1), .bus_ready(ready1), .bus_err(err1),
        .rd_tag_out(rdu1), .done_tag_out(du1)
    );

    // stimulus: wr, addr, data, req tag, wr tag, wake cycle (0 = setup)
    // expected: waits, rdata, rd tag, done tag, err
    localparam int NV = 10;
    localparam logic [107:0] VEC [NV] = '{
        {1'b1, 6'h04, 32'hA5A50001, 8'h3C, 8'h71, 4'd0, 4'd0, 32'h0, 8'h00, 4'hC, 1'b0},
        {1'b1, 6'h1C, 32'h12345678, 8'h05, 8'h99, 4'd3, 4'd2, 32'h0, 8'h00, 4'h5, 1'b0},
        {1'b0, 6'h04, 32'h0,        8'h00, 8'h00, 4'd1, 4'd0, 32'hA5A50001, 8'h71, 4'hC, 1'b0},
        {1'b0, 6'h1C, 32'h0,        8'h00, 8'h00, 4'd2, 4'd1, 32'h12345678, 8'h99, 4'h5, 1'b0},
        {1'b1, 6'h24, 32'hDEADBEEF, 8'hFF, 8'hEE, 4'd0, 4'd0, 32'h0, 8'h00, 4'h0, 1'b1},
        {1'b0, 6'h04, 32'h0,        8'h00, 8'h00, 4'd0, 4'd0, 32'hA5A50001, 8'h71, 4'hC, 1'b0},
        {1'b0, 6'h3C, 32'h0,        8'h00, 8'h00, 4'd1, 4'd0, 32'h0, 8'h00, 4'h0, 1'b1},
        {1'b1, 6'h06, 32'h0000BEEF, 8'h2A, 8'h10, 4'd4, 4'd3, 32'h0, 8'h00, 4'hA, 1'b0},
        {1'b0, 6'h04, 32'h0,        8'h00, 8'h00, 4'd0, 4'd0, 32'h0000BEEF, 8'h10, 4'hA, 1'b0},
        {1'b0, 6'h08, 32'h0,        8'h00, 8'h00, 4'd1, 4'd0, 32'h0, 8'h00, 4'h0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One transfer; wake goes high from cycle wake_at (0 = setup, 1 = first access)
    task automatic xfer(input bit t, input bit w, input logic [5:0] a, input logic [31:0] d,
                        input logic [7:0] at, input logic [7:0] wt, input int wake_at,
                        output int waits, output logic [31:0] rd, output logic [7:0] rdu,
                        output logic [3:0] du, output logic er);
        int  cyc = 1;
        bit  leak = 1'b0;
        waits = -1; rd = '0; rdu = '0; du = '0; er = 1'b0;
        @(negedge clk);
        tgt = t; sel = 1'b1; en = 1'b0; wr = w; addr = a; wdata = d; au = at; wu = wt;
        wake = (wake_at == 0);
        forever begin
            @(negedge clk);
            en = 1'b1;
            wake = (cyc >= wake_at);
            #1;
            if ((t ? ready1 : ready0) == 1'b1) begin
                waits = cyc - 1;
                rd  = t ? rdata1 : rdata0;
                rdu = t ? rdu1 : rdu0;
                du  = t ? du1 : du0;
                er  = t ? err1 : err0;
                break;
            end
            if ((t ? {rdata1, rdu1, du1, err1} : {rdata0, rdu0, du0, err0}) != '0)
                leak = 1'b1;
            cyc++;
            if (cyc > 40) break;
        end
        @(negedge clk);
        sel = 1'b0; en = 1'b0; wake = 1'b0;
        #1;
        chk(!leak, "R5/R6 (R9)", "outputs zero in stalled access cycles", leak, 0);
        chk({ready0, ready1, rdata0, rdata1, err0, err1, rdu0, rdu1, du0, du1} == '0,
            "R9", "idle outputs zero after transfer",
            {ready0, ready1, err0, err1, du0, du1}, 0);
    endtask

    task automatic run_all();
        int waits;
        logic [31:0] rd;
        logic [7:0]  rdu;
        logic [3:0]  du;
        logic        er;

        // R1: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk({ready0, rdata0, err0, rdu0, du0} == '0, "R1", "u0 idle outputs after reset",
            {ready0, err0, rdu0, du0}, 0);
        chk({ready1, rdata1, err1, rdu1, du1} == '0, "R1", "u1 idle outputs after reset",
            {ready1, err1, rdu1, du1}, 0);

        // Table walk on the wake-gated instance
        for (int i = 0; i < NV; i++) begin
            logic [107:0] v;
            v = VEC[i];
            xfer(1'b0, v[107], v[106:101], v[100:69], v[68:61], v[60:53], int'(v[52:49]),
                 waits, rd, rdu, du, er);
            chk(waits == int'(v[48:45]), "R3/R4", $sformatf("vec %0d wait cycles", i),
                waits, v[48:45]);
            chk(rd == v[44:13], "R2 (R1)", $sformatf("vec %0d rdata", i), rd, v[44:13]);
            chk(rdu == v[12:5], "R5", $sformatf("vec %0d read tag", i), rdu, v[12:5]);
            chk(du == v[4:1], "R6", $sformatf("vec %0d done tag", i), du, v[4:1]);
            chk(er == v[0], "R7", $sformatf("vec %0d error flag", i), er, v[0]);
        end

        // R3: wake while idle does not count
        @(negedge clk); wake = 1'b1;
        repeat (3) @(negedge clk);
        xfer(1'b0, 1'b0, 6'h04, 32'h0, 8'h0, 8'h0, 2, waits, rd, rdu, du, er);
        chk(waits == 1, "R3", "idle wake ignored, waits", waits, 1);

        // R4: latch cleared after a woken transfer
        xfer(1'b0, 1'b0, 6'h1C, 32'h0, 8'h0, 8'h0, 0, waits, rd, rdu, du, er);
        chk(waits == 0, "R4", "wake in setup, waits", waits, 0);
        xfer(1'b0, 1'b0, 6'h1C, 32'h0, 8'h0, 8'h0, 3, waits, rd, rdu, du, er);
        chk(waits == 2, "R4", "following transfer stalls again", waits, 2);
        chk(rd == 32'h12345678, "R2", "register 7 unchanged", rd, 32'h12345678);

        // R7: unmapped write left register 1 (aliased index) unchanged earlier; check 0x20
        xfer(1'b0, 1'b1, 6'h20, 32'hFFFF0000, 8'h77, 8'h66, 0, waits, rd, rdu, du, er);
        chk(er == 1'b1, "R7", "unmapped index 8 error", er, 1);
        xfer(1'b0, 1'b0, 6'h00, 32'h0, 8'h0, 8'h0, 0, waits, rd, rdu, du, er);
        chk(rd == 32'h0 && rdu == 8'h0 && du == 4'h0 && er == 1'b0, "R7",
            "register 0 untouched by unmapped write", {rd, rdu, du}, 0);

        // R8: fixed-wait instance, wake never asserted
        xfer(1'b1, 1'b1, 6'h08, 32'h0BADF00D, 8'h11, 8'h22, 99, waits, rd, rdu, du, er);
        chk(waits == 2, "R8", "fixed mode write waits", waits, 2);
        chk(du == 4'h1, "R6", "fixed mode write done tag", du, 1);
        xfer(1'b1, 1'b0, 6'h08, 32'h0, 8'h0, 8'h0, 99, waits, rd, rdu, du, er);
        chk(waits == 2, "R8", "fixed mode read waits", waits, 2);
        chk(rd == 32'h0BADF00D, "R8", "fixed mode read data", rd, 32'h0BADF00D);
        chk(rdu == 8'h22, "R5", "fixed mode read tag", rdu, 8'h22);
        xfer(1'b1, 1'b0, 6'h30, 32'h0, 8'h0, 8'h0, 0, waits, rd, rdu, du, er);
        chk(waits == 2 && er == 1'b1, "R8", "fixed mode unmapped error after waits",
            {waits[7:0], er}, {8'd2, 1'b1});
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                total++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule